// File: doc/BRIEF.md
# RGB Light Sensor Register Target on I2C

This block is the register side of a light sensor. It sits on an I2C bus as a target with a fixed 7-bit address and holds eight byte-wide registers. A controller uses these registers to choose the conversion mode, the interrupt persistence, the resolution and the gain range. It also sets a window of low and high thresholds and reads back the latest conversion result. The block receives the bus lines already sampled into its clock domain. It drives SDA only as an open-drain pull-down enable.

An internal register pointer is loaded by the first byte written after the address byte. Every further data byte, written or read, advances the pointer by one, wrapping from 7 to 0. The conversion logic outside the block reads the configuration fields from dedicated outputs. It supplies each new 16-bit result with a valid strobe and raises an event strobe when a reading falls outside the window. The event sets a sticky flag and pulls the active-low interrupt output. Only a controller read of register 0 clears the flag again.

Top module: `rgbs_i2c_target`

## Requirements
- R1: The target acknowledges (pulls SDA low in the ninth clock) only the address byte 7'b1000110 followed by the R/W bit (0 write, 1 read). Any other address gets no acknowledge, and no later byte is acknowledged, written or driven until the next start.
- R2: A start (SDA falls while SCL is high) begins a new address byte from any state. A stop (SDA rises while SCL is high) returns the target to idle with SDA released, and discards any partly received byte. The SDA enable changes only after an SCL falling edge, a start or a stop.
- R3: In a write transfer, the byte after the address byte loads the pointer from its low 3 bits, and each following byte is stored into the register the pointer selects. Every byte is acknowledged.
- R4: In a read transfer (address+W, pointer byte, repeated start, address+R), the target shifts out the selected register MSB first. A not-acknowledge from the controller ends the read and leaves SDA released.
- R5: After reset, registers 0 to 5 read 00h and registers 6 and 7 read FFh. The interrupt output is high.
- R6: Each data byte written or read advances the pointer by one, wrapping from 7 to 0.
- R7: Registers 2 (result bits 7:0) and 3 (result bits 15:8) load result_i when result_vld_i is high and ignore bus writes.
- R8: Register 0 bits 4:3 and register 1 bits 7:4 and bit 1 always read 0 and ignore writes.
- R9: event_i sets the flag, seen as bit 2 of register 0, and holds int_n_o low. Bus writes to that bit have no effect.
- R10: A bus read of register 0 clears the flag and releases int_n_o when the controller's acknowledge bit for that byte is clocked, not earlier.
- R11: Configuration outputs follow the registers: mode_o = reg0[7:5], persist_o = reg0[1:0], res_sel_o = reg1[3:2], range_o = reg1[0], thresh_lo_o = {reg5, reg4}, thresh_hi_o = {reg7, reg6}. Without a bus write they do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL, already sampled into clk_i |
| sda_i | input | 1 | SDA line level, already sampled into clk_i |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| result_i | input | 16 | Conversion result |
| result_vld_i | input | 1 | Loads result_i into registers 2 and 3 |
| event_i | input | 1 | Out-of-window event, sets the flag |
| mode_o | output | 3 | Operation mode field |
| persist_o | output | 2 | Interrupt persistence field |
| res_sel_o | output | 2 | Resolution select field |
| range_o | output | 1 | Gain range bit |
| thresh_lo_o | output | 16 | Low threshold |
| thresh_hi_o | output | 16 | High threshold |
| int_n_o | output | 1 | Interrupt, low while the flag is set |

## Verification
The bench reads all eight registers in one burst just after reset and a wrapping burst from 7 to 0. Together these catch wrong reset values and wrong pointer stepping. Writes of all-ones to the two command registers separate the stored fields from the reserved and flag bits. A multi-byte threshold write followed by a read checks storage order against the threshold outputs. A foreign address, a stop in the middle of a byte and a write to the result registers must all leave the register contents untouched. The flag is raised, then written, then read, and int_n_o is sampled before and after the controller's acknowledge bit to locate the clear in time.

// File: rtl/rgbs_pkg.sv
package rgbs_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_REGS = 8;
  localparam int REG_AW = $clog2(NUM_REGS);
  localparam int RES_W = 16;
  localparam int THR_BYTES = 4;

  localparam logic [REG_AW-1:0] REG_CMD0  = 3'd0;
  localparam logic [REG_AW-1:0] REG_CMD1  = 3'd1;
  localparam logic [REG_AW-1:0] REG_RES_L = 3'd2;
  localparam logic [REG_AW-1:0] REG_RES_H = 3'd3;
  localparam logic [REG_AW-1:0] REG_THR0  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_PEND, ST_ACK_DRV, ST_TX, ST_TX_REL, ST_MACK, ST_TX_LOAD
  } eng_state_e;

  typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_DATA} rx_kind_e;

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] persist;
    logic [1:0] res_sel;
    logic       range;
  } cfg_t;
endpackage

// File: rtl/rgbs_bus_cond.sv
module rgbs_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA moves while SCL held high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/rgbs_engine.sv
module rgbs_engine
  import rgbs_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'b1000110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [REG_AW-1:0] ptr_o,
  output logic [REG_AW-1:0] op_addr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_done_o,
  output logic              sda_oe_o
);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  eng_state_e        state_q;
  rx_kind_e          kind_q;
  logic [BIT_CW-1:0] bit_cnt_q;
  logic [BYTE_W-1:0] shift_q, tx_q, wr_data_q, byte_w;
  logic [REG_AW-1:0] ptr_q, op_addr_q;
  logic              ack_ok_q, rw_q, wr_en_q, rd_done_q, oe_q;

  assign byte_w = {shift_q[BYTE_W-2:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= RX_ADDR;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      wr_data_q <= '0;
      ptr_q     <= '0;
      op_addr_q <= '0;
      ack_ok_q  <= 1'b0;
      rw_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      rd_done_q <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      wr_en_q   <= 1'b0;
      rd_done_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        kind_q    <= RX_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: if (scl_rise_i) begin
            shift_q <= byte_w;
            if (bit_cnt_q == LAST_BIT) begin
              bit_cnt_q <= '0;
              state_q   <= ST_ACK_PEND;
              op_addr_q <= ptr_q;
              unique case (kind_q)
                RX_ADDR: begin
                  ack_ok_q <= (byte_w[BYTE_W-1:1] == TGT_ADDR);
                  rw_q     <= byte_w[0];
                end
                RX_PTR: begin
                  ack_ok_q <= 1'b1;
                  ptr_q    <= byte_w[REG_AW-1:0];
                end
                default: begin
                  ack_ok_q  <= 1'b1;
                  wr_en_q   <= 1'b1;
                  wr_data_q <= byte_w;
                  ptr_q     <= ptr_q + 1'b1;
                end
              endcase
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_ACK_PEND: if (scl_fall_i) begin
            if (ack_ok_q) begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK_DRV;
            end else begin
              state_q <= ST_IDLE;  // foreign address: deaf until next start
            end
          end
          ST_ACK_DRV: if (scl_fall_i) begin
            if (kind_q == RX_ADDR && rw_q) begin
              tx_q      <= rd_data_i;
              oe_q      <= ~rd_data_i[BYTE_W-1];
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
              kind_q  <= (kind_q == RX_ADDR) ? RX_PTR : RX_DATA;
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              if (bit_cnt_q == LAST_BIT) state_q <= ST_TX_REL;
              else bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              oe_q <= ~tx_q[BYTE_W-2];
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
          ST_TX_REL: if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_MACK;
          end
          ST_MACK: if (scl_rise_i) begin
            rd_done_q <= 1'b1;
            op_addr_q <= ptr_q;
            ptr_q     <= ptr_q + 1'b1;
            state_q   <= sda_i ? ST_IDLE : ST_TX_LOAD;
          end
          ST_TX_LOAD: if (scl_fall_i) begin
            tx_q      <= rd_data_i;
            oe_q      <= ~rd_data_i[BYTE_W-1];
            bit_cnt_q <= '0;
            state_q   <= ST_TX;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign op_addr_o = op_addr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign rd_done_o = rd_done_q;
  assign sda_oe_o  = oe_q;
endmodule

// File: rtl/rgbs_regfile.sv
module rgbs_regfile
  import rgbs_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [REG_AW-1:0]         op_addr_i,
  input  logic [BYTE_W-1:0]         wr_data_i,
  input  logic                      rd_done_i,
  input  logic [REG_AW-1:0]         rd_addr_i,
  output logic [BYTE_W-1:0]         rd_data_o,
  input  logic [RES_W-1:0]          result_i,
  input  logic                      result_vld_i,
  input  logic                      event_i,
  output cfg_t                      cfg_o,
  output logic [THR_BYTES*BYTE_W-1:0] thr_o,
  output logic                      flag_o
);
  localparam int RES_BYTES = RES_W / BYTE_W;

  cfg_t                     cfg_q;
  logic                     flag_q;
  logic [RES_W-1:0]         res_flat;
  logic [THR_BYTES*BYTE_W-1:0] thr_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      if (op_addr_i == REG_CMD0) begin
        cfg_q.mode    <= wr_data_i[7:5];
        cfg_q.persist <= wr_data_i[1:0];
      end
      if (op_addr_i == REG_CMD1) begin
        cfg_q.res_sel <= wr_data_i[3:2];
        cfg_q.range   <= wr_data_i[0];
      end
    end
  end

  // set wins over a clear landing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (event_i) flag_q <= 1'b1;
    else if (rd_done_i && op_addr_i == REG_CMD0) flag_q <= 1'b0;
  end

  for (genvar g = 0; g < RES_BYTES; g++) begin : g_res
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (result_vld_i) q <= result_i[g*BYTE_W +: BYTE_W];
    end
    assign res_flat[g*BYTE_W +: BYTE_W] = q;
  end

  for (genvar g = 0; g < THR_BYTES; g++) begin : g_thr
    localparam logic [BYTE_W-1:0] RST_VAL = (g >= THR_BYTES/2) ? '1 : '0;
    localparam logic [REG_AW-1:0] MY_ADDR = REG_THR0 + REG_AW'(g);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL;
      else if (wr_en_i && op_addr_i == MY_ADDR) q <= wr_data_i;
    end
    assign thr_flat[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    unique case (rd_addr_i)
      REG_CMD0:  rd_data_o = {cfg_q.mode, 2'b00, flag_q, cfg_q.persist};
      REG_CMD1:  rd_data_o = {4'b0000, cfg_q.res_sel, 1'b0, cfg_q.range};
      REG_RES_L: rd_data_o = res_flat[0 +: BYTE_W];
      REG_RES_H: rd_data_o = res_flat[BYTE_W +: BYTE_W];
      default:   rd_data_o = thr_flat[(rd_addr_i - REG_THR0)*BYTE_W +: BYTE_W];
    endcase
  end

  assign cfg_o  = cfg_q;
  assign thr_o  = thr_flat;
  assign flag_o = flag_q;
endmodule

// File: rtl/rgbs_i2c_target.sv
module rgbs_i2c_target
  import rgbs_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'b1000110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [RES_W-1:0] result_i,
  input  logic             result_vld_i,
  input  logic             event_i,
  output logic [2:0]       mode_o,
  output logic [1:0]       persist_o,
  output logic [1:0]       res_sel_o,
  output logic             range_o,
  output logic [15:0]      thresh_lo_o,
  output logic [15:0]      thresh_hi_o,
  output logic             int_n_o
);
  logic scl_rise_w, scl_fall_w, start_w, stop_w;
  logic wr_en_w, rd_done_w, flag_w;
  logic [REG_AW-1:0] ptr_w, op_addr_w;
  logic [BYTE_W-1:0] wr_data_w, rd_data_w;
  logic [THR_BYTES*BYTE_W-1:0] thr_w;
  cfg_t cfg_w;

  rgbs_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  rgbs_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_i),
    .scl_rise_i (scl_rise_w),
    .scl_fall_i (scl_fall_w),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .rd_data_i  (rd_data_w),
    .ptr_o      (ptr_w),
    .op_addr_o  (op_addr_w),
    .wr_en_o    (wr_en_w),
    .wr_data_o  (wr_data_w),
    .rd_done_o  (rd_done_w),
    .sda_oe_o   (sda_oe_o)
  );

  rgbs_regfile u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_w),
    .op_addr_i    (op_addr_w),
    .wr_data_i    (wr_data_w),
    .rd_done_i    (rd_done_w),
    .rd_addr_i    (ptr_w),
    .rd_data_o    (rd_data_w),
    .result_i     (result_i),
    .result_vld_i (result_vld_i),
    .event_i      (event_i),
    .cfg_o        (cfg_w),
    .thr_o        (thr_w),
    .flag_o       (flag_w)
  );

  assign mode_o      = cfg_w.mode;
  assign persist_o   = cfg_w.persist;
  assign res_sel_o   = cfg_w.res_sel;
  assign range_o     = cfg_w.range;
  assign thresh_lo_o = thr_w[15:0];
  assign thresh_hi_o = thr_w[31:16];
  assign int_n_o     = ~flag_w;
endmodule

// File: rtl/rgbs_i2c_target_chk.sv
module rgbs_i2c_target_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sda_oe_o,
  input logic        int_n_o,
  input logic        event_i,
  input logic        scl_fall_i,
  input logic        start_i,
  input logic        stop_i,
  input logic        wr_en_i,
  input logic        rd_done_i,
  input logic [2:0]  op_addr_i,
  input logic [15:0] thresh_lo_o,
  input logic [15:0] thresh_hi_o
);
  assert_oe_timing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall_i || start_i || stop_i));

  assert_stop_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);

  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> !int_n_o);

  assert_flag_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_i && op_addr_i == 3'd0 && !event_i) |=> int_n_o);

  assert_thr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(thresh_lo_o) && $stable(thresh_hi_o)));
endmodule

bind rgbs_i2c_target rgbs_i2c_target_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_oe_o    (sda_oe_o),
  .int_n_o     (int_n_o),
  .event_i     (event_i),
  .scl_fall_i  (scl_fall_w),
  .start_i     (start_w),
  .stop_i      (stop_w),
  .wr_en_i     (wr_en_w),
  .rd_done_i   (rd_done_w),
  .op_addr_i   (op_addr_w),
  .thresh_lo_o (thresh_lo_o),
  .thresh_hi_o (thresh_hi_o)
);

// File: tb/rgbs_i2c_target_tb.sv
module rgbs_i2c_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [6:0] TGT = 7'b1000110;

  typedef struct {string req; logic [15:0] val;} exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [15:0] result = '0;
  logic result_vld = 1'b0, event_in = 1'b0;
  logic sda_oe, range_w, int_n;
  logic [2:0] mode;
  logic [1:0] persist, res_sel;
  logic [15:0] thr_lo, thr_hi;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  logic [15:0] act_q[$];
  logic [7:0] rd_buf[8];
  logic [7:0] wr_buf[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  rgbs_i2c_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .result_i(result), .result_vld_i(result_vld), .event_i(event_in),
    .mode_o(mode), .persist_o(persist), .res_sel_o(res_sel), .range_o(range_w),
    .thresh_lo_o(thr_lo), .thresh_hi_o(thr_hi), .int_n_o(int_n)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      exp_t e;
      logic [15:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (a !== e.val) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", e.req, a, e.val);
      end
    end
  end

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] expv);
    exp_q.push_back('{r, expv});
    act_q.push_back(act);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
  endtask

  task automatic write_burst(input logic [7:0] p, input int n);
    logic ack;
    bus_start();
    put_byte({TGT, 1'b0}, ack); chk("R1 addr+W ack", 16'(ack), 16'd1);
    put_byte(p, ack);           chk("R3 ptr ack", 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) begin
      put_byte(wr_buf[i], ack); chk("R3 data ack", 16'(ack), 16'd1);
    end
    bus_stop();
  endtask

  task automatic read_burst(input logic [7:0] p, input int n);
    logic ack;
    bus_start();
    put_byte({TGT, 1'b0}, ack); chk("R1 addr+W ack", 16'(ack), 16'd1);
    put_byte(p, ack);           chk("R3 ptr ack", 16'(ack), 16'd1);
    bus_start();
    put_byte({TGT, 1'b1}, ack); chk("R1 addr+R ack", 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) begin
      get_byte(rd_buf[i]);
      put_bit(i == n - 1);
    end
    chk("R4 SDA released after NACK", 16'(sda_oe), 16'd0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R5 int_n after reset", 16'(int_n), 16'd1);
    chk("R5 thresh_hi reset", thr_hi, 16'hFFFF);
    chk("R5 thresh_lo reset", thr_lo, 16'h0000);
    chk("R11 mode reset", 16'(mode), 16'd0);
    read_burst(8'h00, 8);
    for (int i = 0; i < 8; i++) chk("R5 reset value", 16'(rd_buf[i]), (i >= 6) ? 16'h00FF : 16'h0000);

    // command registers: stored fields vs reserved/flag bits
    wr_buf[0] = 8'hFF; wr_buf[1] = 8'hFF;
    write_burst(8'h00, 2);
    read_burst(8'h00, 2);
    chk("R8 reg0 reserved zero", 16'(rd_buf[0]), 16'h00E3);
    chk("R8 reg1 reserved zero", 16'(rd_buf[1]), 16'h000D);
    chk("R9 flag ignores write of 1", 16'(int_n), 16'd1);
    chk("R11 mode_o", 16'(mode), 16'd7);
    chk("R11 persist_o", 16'(persist), 16'd3);
    chk("R11 res_sel_o", 16'(res_sel), 16'd3);
    chk("R11 range_o", 16'(range_w), 16'd1);

    // thresholds with pointer advance
    wr_buf[0] = 8'h34; wr_buf[1] = 8'h12; wr_buf[2] = 8'hCD; wr_buf[3] = 8'hAB;
    write_burst(8'h04, 4);
    chk("R11 thresh_lo_o", thr_lo, 16'h1234);
    chk("R11 thresh_hi_o", thr_hi, 16'hABCD);
    read_burst(8'h04, 4);
    chk("R6 read reg4", 16'(rd_buf[0]), 16'h0034);
    chk("R6 read reg5", 16'(rd_buf[1]), 16'h0012);
    chk("R6 read reg6", 16'(rd_buf[2]), 16'h00CD);
    chk("R6 read reg7", 16'(rd_buf[3]), 16'h00AB);

    // result registers are read-only
    wr_buf[0] = 8'h55; wr_buf[1] = 8'hAA;
    write_burst(8'h02, 2);
    read_burst(8'h02, 2);
    chk("R7 reg2 ignores write", 16'(rd_buf[0]), 16'h0000);
    chk("R7 reg3 ignores write", 16'(rd_buf[1]), 16'h0000);
    result = 16'hBEEF; result_vld = 1'b1; @(negedge clk); result_vld = 1'b0; result = '0;
    read_burst(8'h02, 2);
    chk("R7 result lsb", 16'(rd_buf[0]), 16'h00EF);
    chk("R7 result msb", 16'(rd_buf[1]), 16'h00BE);

    // foreign address ignored
    bus_start();
    put_byte({7'b1000111, 1'b0}, ack); chk("R1 foreign addr nack", 16'(ack), 16'd0);
    put_byte(8'h04, ack);              chk("R1 ignored ptr nack", 16'(ack), 16'd0);
    put_byte(8'h99, ack);              chk("R1 ignored data nack", 16'(ack), 16'd0);
    bus_stop();
    bus_start();
    put_byte({7'b0000110, 1'b1}, ack); chk("R1 foreign read nack", 16'(ack), 16'd0);
    get_byte(b);                       chk("R1 no data driven", 16'(b), 16'h00FF);
    put_bit(1'b1);
    bus_stop();
    read_burst(8'h04, 1);
    chk("R1 reg4 unchanged", 16'(rd_buf[0]), 16'h0034);

    // stop inside a data byte
    bus_start();
    put_byte({TGT, 1'b0}, ack); chk("R2 addr ack", 16'(ack), 16'd1);
    put_byte(8'h05, ack);       chk("R2 ptr ack", 16'(ack), 16'd1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    chk("R2 SDA released after stop", 16'(sda_oe), 16'd0);
    read_burst(8'h05, 1);
    chk("R2 partial byte discarded", 16'(rd_buf[0]), 16'h0012);

    // interrupt flag
    event_in = 1'b1; @(negedge clk); event_in = 1'b0; @(negedge clk);
    chk("R9 int_n low after event", 16'(int_n), 16'd0);
    wr_buf[0] = 8'h00;
    write_burst(8'h00, 1);
    chk("R9 flag ignores write of 0", 16'(int_n), 16'd0);
    bus_start();
    put_byte({TGT, 1'b0}, ack); chk("R4 addr+W ack", 16'(ack), 16'd1);
    put_byte(8'h00, ack);       chk("R4 ptr ack", 16'(ack), 16'd1);
    bus_start();
    put_byte({TGT, 1'b1}, ack); chk("R4 addr+R ack", 16'(ack), 16'd1);
    get_byte(b);
    chk("R9 flag bit in reg0", 16'(b), 16'h0004);
    chk("R10 flag held until ack bit", 16'(int_n), 16'd0);
    put_bit(1'b1);
    chk("R10 flag cleared after read", 16'(int_n), 16'd1);
    chk("R4 SDA released after NACK", 16'(sda_oe), 16'd0);
    bus_stop();

    // wrap of pointer 7 -> 0
    read_burst(8'h07, 2);
    chk("R6 wrap reg7", 16'(rd_buf[0]), 16'h00AB);
    chk("R6 wrap reg0", 16'(rd_buf[1]), 16'h0000);

    repeat (10) @(negedge clk);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule